// File: doc/BRIEF.md
# HDLC Data Link Frame Transmitter

This block turns bytes written by a processor into a bit-serial HDLC stream for a low-rate data link channel. A small register set holds a configuration word, a status word and a one-byte holding register. Software writes message bytes one at a time. The last byte goes to a separate address that marks the end of the message. When enabled, the transmitter sends flags, performs zero-bit insertion, can append a 16-bit frame check sequence, and closes each frame with a flag.

Serial timing comes from a one-cycle bit strobe supplied by the surrounding framer. The block advances by one line bit per strobe.

A request output asks for the next byte. It can drive a processor interrupt or a DMA request. If a byte is missing when it is needed, the frame is aborted and a separate sticky underrun output is raised so that the exception can be handled. Software clears the underrun and restarts the frame from its first byte. With nothing to send, the line carries flags back to back.

Top module: `hdlc_link_tx`

## Requirements
- R1: After reset the configuration reads 0, `tx_bit_o` is 1, and `req_o` and `udr_o` are 0. While the enable bit (address 0, bit 0) is 0, the line holds 1 and writes to the data addresses are ignored.
- R2: When enabled with no byte pending, the line carries the flag 0x7E, LSB first, back to back with no gap.
- R3: A frame is an opening flag, then the data bytes each sent LSB first, then an optional FCS, then a closing flag.
- R4: After five consecutive 1s in data or FCS bits, a 0 is inserted, including at the end of the last FCS bit. Flags and aborts get no insertion.
- R5: When address 0 bit 1 is 1, the FCS is appended. It is CRC-16 with polynomial x^16+x^12+x^5+1, processed LSB first (reflected constant 0x8408), preset to 0xFFFF, and sent complemented, low byte first. When the bit is 0, no FCS is sent.
- R6: Status bit 0 (address 1) reads 1 when the block is enabled and the holding register is empty. A write to address 2 or 3 fills the holding register, and the bit reads 0 from the next cycle. The bit returns to 1 once the byte moves into the shifter. A data write while the register is full is ignored.
- R7: `req_o` equals status bit 0 gated by address 0 bit 2. While that enable bit is 0, `req_o` stays 0.
- R8: If a byte ends with no end mark and no next byte is waiting, the block sends an abort of 8 consecutive 1s. Underrun is raised on the first abort bit, and flag fill follows the abort.
- R9: Underrun (status bit 1, mirrored on `udr_o`) stays set until a write to address 1 has bit 1 equal to 0. A write with bit 1 equal to 1 leaves it set.
- R10: A byte written to address 3 is the last of its frame: after it, the FCS (if enabled) and the closing flag are sent, with no further data request for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| bit_en_i | input | 1 | one-cycle strobe; advances the line by one bit |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | 2 | write address: 0 config, 1 status, 2 data, 3 last data |
| wr_data_i | input | 8 | write data |
| rd_addr_i | input | 2 | read address |
| rd_data_o | output | 8 | read data (combinational) |
| tx_bit_o | output | 1 | serial line output |
| req_o | output | 1 | byte request (interrupt or DMA request) |
| udr_o | output | 1 | sticky underrun |

## Verification
A scoreboard decodes the line: it finds flags, removes inserted zeros, and compares every frame and abort against what the driver queued. The stuffing frames use 0xFF and 0x7E bytes. A design that misses insertion, or skips it after the final FCS bit, would make the decoder see a false flag or abort, or read a misaligned frame. Frames with the FCS on and off catch a wrong preset, a wrong bit order or a missing complement, because each of these changes the decoded trailing bytes. The bench also covers:
- A byte left without its successor, which must produce exactly one abort and a sticky underrun.
- A second write while the holding register is full, which must not appear in the frame.
- Writes made while disabled, which must never leak out.

// File: rtl/hdlc_link_pkg.sv
package hdlc_link_pkg;
  localparam logic [7:0]  FLAG_OCTET = 8'h7E;
  localparam int          FLAG_LEN   = 8;
  localparam int          A_CFG      = 0;
  localparam int          A_STAT     = 1;
  localparam int          A_DATA     = 2;
  localparam int          A_LAST     = 3;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_FLAG,
    ST_DATA,
    ST_FCS,
    ST_ABORT
  } tx_state_e;
endpackage

// File: rtl/hdlc_link_regs.sv
module hdlc_link_regs
  import hdlc_link_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              pop_i,
  input  logic              udr_set_i,
  output logic              en_o,
  output logic              fcs_en_o,
  output logic              req_en_o,
  output logic [DATA_W-1:0] hold_data_o,
  output logic              hold_last_o,
  output logic              hold_full_o,
  output logic              data_req_o,
  output logic              udr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int CFG_W = 3;

  logic [CFG_W-1:0]  cfg_q;
  logic [DATA_W-1:0] data_q;
  logic              last_q, full_q, udr_q;
  logic              wr_cfg, wr_stat, wr_byte;

  assign wr_cfg  = wr_en_i && (wr_addr_i == ADDR_W'(A_CFG));
  assign wr_stat = wr_en_i && (wr_addr_i == ADDR_W'(A_STAT));
  assign wr_byte = wr_en_i && ((wr_addr_i == ADDR_W'(A_DATA)) ||
                               (wr_addr_i == ADDR_W'(A_LAST)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      data_q <= '0;
      last_q <= 1'b0;
      full_q <= 1'b0;
      udr_q  <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= wr_data_i[CFG_W-1:0];
      // holding register is flushed while disabled
      if (!cfg_q[0] || pop_i) begin
        full_q <= 1'b0;
      end else if (wr_byte && !full_q) begin
        full_q <= 1'b1;
        data_q <= wr_data_i;
        last_q <= (wr_addr_i == ADDR_W'(A_LAST));
      end
      if (udr_set_i)                    udr_q <= 1'b1;
      else if (wr_stat && !wr_data_i[1]) udr_q <= 1'b0;
    end
  end

  assign en_o        = cfg_q[0];
  assign fcs_en_o    = cfg_q[1];
  assign req_en_o    = cfg_q[2];
  assign hold_data_o = data_q;
  assign hold_last_o = last_q;
  assign hold_full_o = full_q;
  assign data_req_o  = cfg_q[0] & ~full_q;
  assign udr_o       = udr_q;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_W'(A_CFG):  rd_data_o = DATA_W'(cfg_q);
      ADDR_W'(A_STAT): rd_data_o = DATA_W'({udr_q, data_req_o});
      default:         rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/hdlc_link_crc.sv
module hdlc_link_crc #(
  parameter int             FCS_W = 16,
  parameter logic [FCS_W-1:0] POLY = 16'h8408
) (
  input  logic [FCS_W-1:0] crc_i,
  input  logic             bit_i,
  output logic [FCS_W-1:0] crc_o
);
  logic fb;
  assign fb    = crc_i[0] ^ bit_i;
  assign crc_o = (crc_i >> 1) ^ (fb ? POLY : '0);
endmodule

// File: rtl/hdlc_link_ser.sv
module hdlc_link_ser
  import hdlc_link_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FCS_W     = 16,
  parameter int STUFF_RUN = 5,
  parameter int ABORT_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              en_i,
  input  logic              fcs_en_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  logic              hold_last_i,
  input  logic              hold_full_i,
  output logic              pop_o,
  output logic              udr_set_o,
  output logic              tx_bit_o
);
  localparam int CNT_W  = $clog2(FCS_W);
  localparam int ONES_W = $clog2(STUFF_RUN + 1);
  localparam logic [FCS_W-1:0] CRC_PRESET = '1;

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ONES_W-1:0] ones_q, ones_d, ones_nx;
  logic [FCS_W-1:0]  sh_q, sh_d, crc_q, crc_d, crc_nx;
  logic              stuff_q, stuff_d, last_q, last_d, tx_q, tx_d;

  hdlc_link_crc #(.FCS_W(FCS_W)) u_crc (
    .crc_i (crc_q),
    .bit_i (sh_q[0]),
    .crc_o (crc_nx)
  );

  assign ones_nx = sh_q[0] ? ones_q + 1'b1 : '0;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    ones_d    = ones_q;
    sh_d      = sh_q;
    crc_d     = crc_q;
    stuff_d   = stuff_q;
    last_d    = last_q;
    tx_d      = tx_q;
    pop_o     = 1'b0;
    udr_set_o = 1'b0;
    if (bit_en_i) begin
      if (!en_i) begin
        state_d = ST_OFF;
        cnt_d   = '0;
        ones_d  = '0;
        stuff_d = 1'b0;
        tx_d    = 1'b1;
      end else if (stuff_q) begin
        // inserted zero occupies this slot, nothing else advances
        tx_d    = 1'b0;
        stuff_d = 1'b0;
      end else begin
        case (state_q)
          ST_OFF: begin
            state_d = ST_FLAG;
            cnt_d   = '0;
            tx_d    = 1'b1;
          end
          ST_FLAG: begin
            tx_d   = FLAG_OCTET[cnt_q[2:0]];
            cnt_d  = cnt_q + 1'b1;
            ones_d = '0;
            if (cnt_q == CNT_W'(FLAG_LEN - 1)) begin
              cnt_d = '0;
              if (hold_full_i) begin
                state_d = ST_DATA;
                sh_d    = FCS_W'(hold_data_i);
                last_d  = hold_last_i;
                crc_d   = CRC_PRESET;
                pop_o   = 1'b1;
              end
            end
          end
          ST_DATA, ST_FCS: begin
            tx_d  = sh_q[0];
            sh_d  = sh_q >> 1;
            cnt_d = cnt_q + 1'b1;
            if (ones_nx == ONES_W'(STUFF_RUN)) begin
              stuff_d = 1'b1;
              ones_d  = '0;
            end else begin
              ones_d = ones_nx;
            end
            if (state_q == ST_DATA) begin
              crc_d = crc_nx;
              if (cnt_q == CNT_W'(DATA_W - 1)) begin
                cnt_d = '0;
                if (last_q) begin
                  if (fcs_en_i) begin
                    state_d = ST_FCS;
                    sh_d    = ~crc_nx;
                  end else begin
                    state_d = ST_FLAG;
                  end
                end else if (hold_full_i) begin
                  sh_d   = FCS_W'(hold_data_i);
                  last_d = hold_last_i;
                  pop_o  = 1'b1;
                end else begin
                  state_d = ST_ABORT;
                end
              end
            end else if (cnt_q == CNT_W'(FCS_W - 1)) begin
              cnt_d   = '0;
              state_d = ST_FLAG;
            end
          end
          ST_ABORT: begin
            tx_d   = 1'b1;
            ones_d = '0;
            cnt_d  = cnt_q + 1'b1;
            if (cnt_q == '0) udr_set_o = 1'b1;
            if (cnt_q == CNT_W'(ABORT_LEN - 1)) begin
              cnt_d   = '0;
              state_d = ST_FLAG;
            end
          end
          default: state_d = ST_OFF;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      ones_q  <= '0;
      sh_q    <= '0;
      crc_q   <= CRC_PRESET;
      stuff_q <= 1'b0;
      last_q  <= 1'b0;
      tx_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ones_q  <= ones_d;
      sh_q    <= sh_d;
      crc_q   <= crc_d;
      stuff_q <= stuff_d;
      last_q  <= last_d;
      tx_q    <= tx_d;
    end
  end

  assign tx_bit_o = tx_q;
endmodule

// File: rtl/hdlc_link_tx.sv
module hdlc_link_tx #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int FCS_W     = 16,
  parameter int STUFF_RUN = 5,
  parameter int ABORT_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              tx_bit_o,
  output logic              req_o,
  output logic              udr_o
);
  logic              cfg_en, cfg_fcs, cfg_req_en;
  logic [DATA_W-1:0] hold_data;
  logic              hold_last, hold_full, data_req, pop, udr_set;

  hdlc_link_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_addr_i   (rd_addr_i),
    .pop_i       (pop),
    .udr_set_i   (udr_set),
    .en_o        (cfg_en),
    .fcs_en_o    (cfg_fcs),
    .req_en_o    (cfg_req_en),
    .hold_data_o (hold_data),
    .hold_last_o (hold_last),
    .hold_full_o (hold_full),
    .data_req_o  (data_req),
    .udr_o       (udr_o),
    .rd_data_o   (rd_data_o)
  );

  hdlc_link_ser #(
    .DATA_W    (DATA_W),
    .FCS_W     (FCS_W),
    .STUFF_RUN (STUFF_RUN),
    .ABORT_LEN (ABORT_LEN)
  ) u_ser (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_en_i    (bit_en_i),
    .en_i        (cfg_en),
    .fcs_en_i    (cfg_fcs),
    .hold_data_i (hold_data),
    .hold_last_i (hold_last),
    .hold_full_i (hold_full),
    .pop_o       (pop),
    .udr_set_o   (udr_set),
    .tx_bit_o    (tx_bit_o)
  );

  assign req_o = data_req & cfg_req_en;
endmodule

// File: rtl/hdlc_link_tx_chk.sv
module hdlc_link_tx_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              en_i,
  input logic              req_en_i,
  input logic              data_req_i,
  input logic              tx_bit_i,
  input logic              req_i,
  input logic              udr_i
);
  // R9
  udr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (udr_i && !(wr_en_i && wr_addr_i == ADDR_W'(1) && !wr_data_i[1])) |=> udr_i);

  // R6
  req_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i[1] && data_req_i) |=> !data_req_i);

  // R8
  abort_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(udr_i) |-> tx_bit_i);

  // R7
  req_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_en_i |-> !req_i);

  // R1
  off_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!req_i && !data_req_i));
endmodule

bind hdlc_link_tx hdlc_link_tx_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .en_i       (cfg_en),
  .req_en_i   (cfg_req_en),
  .data_req_i (data_req),
  .tx_bit_i   (tx_bit_o),
  .req_i      (req_o),
  .udr_i      (udr_o)
);

// File: tb/hdlc_link_tx_test.sv
module hdlc_link_tx_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [1:0] rd_addr_i = 2'd1;
  logic [7:0] rd_data_o;
  logic       tx_bit_o, req_o, udr_o;

  hdlc_link_tx uut (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  int exp_len_q[$];
  logic [7:0] exp_byte_q[$];
  logic [7:0] fbuf [0:7];
  bit   rx_bits [0:1023];
  int   rx_n = 0, ones = 0, flag_cnt = 0, frame_cnt = 0;
  bit   in_frame = 0, done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // scoreboard side
  task automatic on_frame(input int n);
    int len;
    logic [7:0] b, e;
    frame_cnt++;
    check(n % 8 == 0, "R3", "frame bit count multiple of 8", n % 8, 0);
    if (exp_len_q.size() == 0) begin
      check(0, "R3", "unexpected frame", n / 8, 0);
      return;
    end
    len = exp_len_q.pop_front();
    check(len == n / 8, "R3", "frame length", n / 8, len);
    for (int i = 0; i < len; i++) begin
      b = '0;
      for (int k = 0; k < 8; k++)
        if (i * 8 + k < n) b[k] = rx_bits[i * 8 + k];
      e = exp_byte_q.pop_front();
      if (b != e) check(0, "R4/R5", "frame byte", b, e);
    end
  endtask

  task automatic on_abort();
    int len;
    if (exp_len_q.size() == 0) begin
      check(0, "R8", "unexpected abort", 0, -1);
      return;
    end
    len = exp_len_q.pop_front();
    check(len == -1, "R8", "abort seen in place of frame", -1, len);
  endtask

  task automatic rx_bit(input bit b);
    if (b) begin
      ones++;
      if (in_frame) begin
        if (ones >= 7) begin
          in_frame = 0;
          on_abort();
        end else begin
          rx_bits[rx_n] = 1'b1;
          rx_n++;
        end
      end
    end else begin
      if (ones == 6) begin
        flag_cnt++;
        if (in_frame && rx_n > 7) on_frame(rx_n - 7);
        in_frame = 1;
        rx_n = 0;
      end else if (in_frame && ones != 5) begin
        rx_bits[rx_n] = 1'b0;
        rx_n++;
      end
      ones = 0;
    end
    if (rx_n > 1000) rx_n = 1000;
  endtask

  // bit strobe and monitor
  initial begin
    forever begin
      repeat (3) @(negedge clk_i);
      bit_en_i = 1'b1;
      @(negedge clk_i);
      bit_en_i = 1'b0;
      if (rst_ni) rx_bit(tx_bit_o);
    end
  end

  function automatic logic [15:0] fcs_of(input int n);
    logic [15:0] c = 16'hFFFF;
    bit fb;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        fb = c[0] ^ fbuf[i][k];
        c  = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr_i = a;
    #1 d = rd_data_o;
    rd_addr_i = 2'd1;
    #1;
  endtask

  task automatic wait_int();
    int t = 0;
    while (!rd_data_o[0] && t < 4000) begin
      @(negedge clk_i);
      t++;
    end
  endtask

  // driver: pushes expected items, then feeds bytes as requested
  task automatic send_frame(input int n, input bit fcs, input bit push);
    logic [15:0] f;
    if (push) begin
      exp_len_q.push_back(fcs ? n + 2 : n);
      for (int i = 0; i < n; i++) exp_byte_q.push_back(fbuf[i]);
      if (fcs) begin
        f = fcs_of(n);
        exp_byte_q.push_back(f[7:0]);
        exp_byte_q.push_back(f[15:8]);
      end
    end
    for (int i = 0; i < n; i++) begin
      wait_int();
      wr((i == n - 1) ? 2'd3 : 2'd2, fbuf[i]);
    end
  endtask

  task automatic drain();
    int t = 0;
    while (exp_len_q.size() != 0 && t < 20000) begin
      @(negedge clk_i);
      t++;
    end
    repeat (120) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    check(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int f0;
    bit stay;
    repeat (3) @(negedge clk_i);
    rd(2'd0, d);
    check(d == 8'h00 && tx_bit_o && !req_o && !udr_o, "R1", "reset state",
          {d, tx_bit_o, req_o, udr_o}, 8'h04);
    rst_ni = 1'b1;

    // R1: data writes ignored while disabled, line idles high
    wr(2'd3, 8'h55);
    stay = 1;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk_i);
      if (!tx_bit_o) stay = 0;
    end
    check(stay, "R1", "line high while disabled", 0, 1);
    check(rd_data_o == 8'h00, "R1", "status while disabled", rd_data_o, 0);

    // R2 and R7: enable, fcs on, request gate off
    wr(2'd0, 8'h03);
    @(negedge clk_i);
    check(rd_data_o[0] == 1'b1 && !req_o, "R7", "status set, req gated",
          {rd_data_o[0], req_o}, 2'b10);
    f0 = flag_cnt;
    repeat (256) @(negedge clk_i);
    check(flag_cnt - f0 >= 7 && frame_cnt == 0, "R2", "flag fill count",
          flag_cnt - f0, 7);
    wr(2'd0, 8'h07);
    @(negedge clk_i);
    check(req_o == 1'b1, "R7", "req with enable", req_o, 1);

    // R3 R5 R10: basic frame with FCS, request drops after write (R6)
    fbuf[0] = 8'h12; fbuf[1] = 8'h34; fbuf[2] = 8'hA5;
    exp_len_q.push_back(5);
    for (int i = 0; i < 3; i++) exp_byte_q.push_back(fbuf[i]);
    begin
      logic [15:0] f;
      f = fcs_of(3);
      exp_byte_q.push_back(f[7:0]);
      exp_byte_q.push_back(f[15:8]);
    end
    wait_int();
    wr(2'd2, fbuf[0]);
    check(rd_data_o[0] == 1'b0 && !req_o, "R6", "status clears after write",
          rd_data_o[0], 0);
    wait_int();
    check(rd_data_o[0] == 1'b1, "R6", "status back after load", rd_data_o[0], 1);
    wr(2'd2, fbuf[1]);
    wait_int();
    wr(2'd3, fbuf[2]);
    drain();
    check(exp_len_q.size() == 0, "R10", "frame closed after last byte",
          exp_len_q.size(), 0);

    // R4: stuffing-heavy payload
    fbuf[0] = 8'hFF; fbuf[1] = 8'h7E; fbuf[2] = 8'hFF; fbuf[3] = 8'h1F;
    send_frame(4, 1, 1);
    drain();
    check(exp_len_q.size() == 0, "R4", "stuffed frame decoded", exp_len_q.size(), 0);

    // R5: FCS off
    wr(2'd0, 8'h05);
    fbuf[0] = 8'h3C; fbuf[1] = 8'hF0;
    send_frame(2, 0, 1);
    drain();
    check(exp_len_q.size() == 0, "R5", "frame without FCS", exp_len_q.size(), 0);
    wr(2'd0, 8'h07);

    // R6: write while full ignored
    fbuf[0] = 8'hC3;
    send_frame(1, 1, 1);
    wr(2'd3, 8'h99);
    drain();
    check(exp_len_q.size() == 0 && exp_byte_q.size() == 0, "R6",
          "write while full dropped", exp_byte_q.size(), 0);

    // R8 R9: underrun
    exp_len_q.push_back(-1);
    wait_int();
    wr(2'd2, 8'hA1);
    begin
      int t = 0;
      while (!udr_o && t < 4000) begin
        @(negedge clk_i);
        t++;
      end
    end
    check(udr_o == 1'b1, "R8", "underrun raised", udr_o, 1);
    drain();
    check(exp_len_q.size() == 0, "R8", "abort observed", exp_len_q.size(), 0);
    check(rd_data_o[1] == 1'b1 && udr_o, "R9", "underrun sticky", rd_data_o[1], 1);
    wr(2'd1, 8'h02);
    check(udr_o == 1'b1, "R9", "write of 1 keeps underrun", udr_o, 1);
    f0 = flag_cnt;
    repeat (200) @(negedge clk_i);
    check(flag_cnt - f0 >= 5, "R8", "flag fill after abort", flag_cnt - f0, 5);
    wr(2'd1, 8'h00);
    check(udr_o == 1'b0 && rd_data_o[1] == 1'b0, "R9", "underrun cleared", udr_o, 0);

    // R8: restart frame after clearing
    fbuf[0] = 8'hA1; fbuf[1] = 8'h00; fbuf[2] = 8'h5F;
    send_frame(3, 1, 1);
    drain();
    check(exp_len_q.size() == 0 && !udr_o, "R8", "restarted frame",
          exp_len_q.size(), 0);
    finish_run();
  end
endmodule